// File: doc/BRIEF.md
# High-Resolution Edge Timestamp Capture

This block stamps transitions on a single input pin with a time finer than one loop period. A fast clock drives a sub-loop counter that restarts at the start of every loop. A loop lasts a programmable power-of-two number of fast clocks. A coarse loop counter advances once per loop and wraps at a programmable ceiling. When a transition of the selected polarity arrives, the sub-loop count and the coarse count of that loop are merged into one 32-bit stamp. The stamp is published at the boundary that closes the loop, together with a one-cycle strobe.

A mode input selects between fine stamping and loop-only stamping. In loop-only mode the pin is judged once per loop, and the sub-loop part of the stamp is zero. The stamp puts the coarse count in its upper 25 bits. The sub-loop count is left-justified in the lower 7 bits, so the number of meaningful low bits grows with the loop length.

Top module: `hr_edge_stamp`

## Requirements
- R1: A synchronous reset clears the stamp to 0 and holds the strobe low. The stamp stays 0 until the first capture after reset.
- R2: In the first cycle after reset the sub-loop count and the coarse count are both 0. The sub-loop count runs from 0 to 2^`prescale_i`-1, so a loop is 2^`prescale_i` clocks long, with `prescale_i` from 0 to 7. The coarse count rises by one at each loop boundary.
- R3: `edge_sel_i` selects the polarity: 0 captures nothing, 1 captures rising transitions, 2 captures falling transitions and 3 captures both.
- R4: The pin passes through two flip-flops before it is judged. A level driven in cycle m is judged in cycle m+2, and the sub-loop count of cycle m+2 is the one latched.
- R5: Only the first qualifying transition in a loop is captured. Later transitions in the same loop leave the pending stamp unchanged.
- R6: Stamp layout: bits [31:7] hold the coarse count of the loop in which the transition was judged. The sub-loop count fills the top `prescale_i` bits of [6:0], and the bits below it are 0. Example: with 4 clocks per loop, coarse 4 and sub-loop 2 give 0x0240.
- R7: A stamp is published at the edge that ends the loop of its transition. The strobe is high for exactly the first cycle of the next loop, and the stamp holds its value at all other times.
- R8: A transition judged in the last cycle of a loop is published at that same loop's end.
- R9: With `lr_mode_i`=1, the synchronized pin is compared once per loop, in its last cycle, with the level sampled at the previous loop's last cycle. Bits [6:0] of the stamp are 0.
- R10: The coarse count wraps from `loop_max_i` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (sub-loop) clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous pin to be stamped |
| edge_sel_i | input | 2 | Polarity select: 0 none, 1 rise, 2 fall, 3 both |
| lr_mode_i | input | 1 | 1 = loop-only stamping, 0 = fine stamping |
| prescale_i | input | 3 | log2 of fast clocks per loop |
| loop_max_i | input | 25 | Ceiling of the coarse counter before wrap |
| cap_word_o | output | 32 | Published stamp |
| cap_valid_o | output | 1 | One-cycle strobe on publication |

## Verification
The hardest cases to reach from the ports depend on where a transition falls inside a loop. One is a transition judged in the very last cycle of a loop. Another is a second transition arriving in the same loop as the first. A third is loop-only mode, where the level is sampled only at loop ends. Each case needs the pin driven a precise number of cycles after reset. The bench counts clocks from the release of reset and drives the pin in a chosen cycle m, so that the judged cycle m+2 falls where the test needs it. Examples are the last clock of a loop, two transitions within one loop, and a cycle just before a loop-end sample.

// File: rtl/hrts_pkg.sv
package hrts_pkg;

    localparam int LOOP_BITS  = 25;
    localparam int SUB_BITS   = 7;
    localparam int PS_BITS    = $clog2(SUB_BITS + 1);
    localparam int WORD_BITS  = LOOP_BITS + SUB_BITS;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_t;

    // Qualify a level change against the polarity selection.
    function automatic logic edge_match(input logic prev, input logic cur,
                                        input logic [1:0] sel);
        logic hit;
        case (edge_sel_t'(sel))
            EDGE_RISE: hit = !prev && cur;
            EDGE_FALL: hit = prev && !cur;
            EDGE_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/hrts_timebase.sv
module hrts_timebase
    import hrts_pkg::*;
#(
    parameter int LOOP_W = LOOP_BITS,
    parameter int SUB_W  = SUB_BITS,
    parameter int PS_W   = PS_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PS_W-1:0]   prescale_i,
    input  logic [LOOP_W-1:0] loop_max_i,
    output logic [SUB_W-1:0]  hr_cnt_o,
    output logic [LOOP_W-1:0] loop_cnt_o,
    output logic              loop_last_o
);

    localparam logic [SUB_W:0] ONE_EXT = (SUB_W+1)'(1);

    typedef struct packed {
        logic [SUB_W-1:0]  hr;
        logic [LOOP_W-1:0] loop;
    } tb_state_t;

    tb_state_t        st_q, st_d;
    logic [SUB_W:0]   span;
    logic [SUB_W-1:0] sub_top;
    logic             last;

    always_comb begin
        span    = ONE_EXT << prescale_i;
        sub_top = SUB_W'(span - ONE_EXT);
        // >= keeps the counter bounded if the prescale shrinks mid-loop
        last    = (st_q.hr >= sub_top);
        st_d    = st_q;
        if (last) begin
            st_d.hr   = '0;
            st_d.loop = (st_q.loop >= loop_max_i) ? '0 : st_q.loop + 1'b1;
        end else begin
            st_d.hr   = st_q.hr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hr_cnt_o    = st_q.hr;
    assign loop_cnt_o  = st_q.loop;
    assign loop_last_o = last;

endmodule

// File: rtl/hrts_edge_detect.sv
module hrts_edge_detect
    import hrts_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    input  logic       loop_last_i,
    output logic       hr_hit_o,
    output logic       lr_hit_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   lvl;
    } ed_state_t;

    ed_state_t              st_q, st_d;
    logic [SYNC_STAGES-1:0] chain_in;
    logic                   pin_s;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_head
                assign chain_in[g] = pin_i;
            end else begin : g_tail
                assign chain_in[g] = st_q.sync[g-1];
            end
        end
    endgenerate

    assign pin_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = chain_in;
        st_d.prev = pin_s;
        st_d.lvl  = loop_last_i ? pin_s : st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Fine-rate detection: every clock against the previous clock's level.
    assign hr_hit_o = edge_match(st_q.prev, pin_s, edge_sel_i);
    // Loop-rate detection: last clock of a loop against the previous loop's sample.
    assign lr_hit_o = loop_last_i && edge_match(st_q.lvl, pin_s, edge_sel_i);

endmodule

// File: rtl/hrts_capture.sv
module hrts_capture
    import hrts_pkg::*;
#(
    parameter int LOOP_W = LOOP_BITS,
    parameter int SUB_W  = SUB_BITS,
    parameter int PS_W   = PS_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lr_mode_i,
    input  logic [PS_W-1:0]         prescale_i,
    input  logic                    hr_hit_i,
    input  logic                    lr_hit_i,
    input  logic                    loop_last_i,
    input  logic [SUB_W-1:0]        hr_cnt_i,
    input  logic [LOOP_W-1:0]       loop_cnt_i,
    output logic [LOOP_W+SUB_W-1:0] word_o,
    output logic                    valid_o
);

    localparam int WORD_W = LOOP_W + SUB_W;

    typedef struct packed {
        logic                armed;
        logic [SUB_W-1:0]    hr_cap;
        logic [LOOP_W-1:0]   loop_cap;
        logic [WORD_W-1:0]   word;
        logic                valid;
    } cap_state_t;

    cap_state_t       st_q, st_d;
    logic             take_hr;
    logic [PS_W-1:0]  shamt;

    // Left-justify the sub-loop count into the fine field.
    function automatic logic [SUB_W-1:0] justify(input logic [SUB_W-1:0] hr,
                                                 input logic [PS_W-1:0]  sh,
                                                 input logic             zero);
        logic [SUB_W-1:0] f;
        f = hr << sh;
        return zero ? '0 : f;
    endfunction

    always_comb begin
        shamt      = PS_W'(SUB_W) - prescale_i;
        take_hr    = !lr_mode_i && hr_hit_i && !st_q.armed;
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (loop_last_i) begin
            if (lr_mode_i) begin
                if (lr_hit_i) begin
                    st_d.word  = {loop_cnt_i, {SUB_W{1'b0}}};
                    st_d.valid = 1'b1;
                end
            end else if (st_q.armed) begin
                st_d.word  = {st_q.loop_cap, justify(st_q.hr_cap, shamt, 1'b0)};
                st_d.valid = 1'b1;
            end else if (take_hr) begin
                st_d.word  = {loop_cnt_i, justify(hr_cnt_i, shamt, 1'b0)};
                st_d.valid = 1'b1;
            end
            st_d.armed = 1'b0;
        end else if (take_hr) begin
            st_d.armed    = 1'b1;
            st_d.hr_cap   = hr_cnt_i;
            st_d.loop_cap = loop_cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/hr_edge_stamp.sv
module hr_edge_stamp
    import hrts_pkg::*;
#(
    parameter int LOOP_W = LOOP_BITS,
    parameter int SUB_W  = SUB_BITS,
    parameter int PS_W   = PS_BITS,
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pin_i,
    input  logic [1:0]              edge_sel_i,
    input  logic                    lr_mode_i,
    input  logic [PS_W-1:0]         prescale_i,
    input  logic [LOOP_W-1:0]       loop_max_i,
    output logic [LOOP_W+SUB_W-1:0] cap_word_o,
    output logic                    cap_valid_o
);

    logic [SUB_W-1:0]  hr_cnt_w;
    logic [LOOP_W-1:0] loop_cnt_w;
    logic              loop_last_w;
    logic              hr_hit_w;
    logic              lr_hit_w;

    hrts_timebase #(.LOOP_W(LOOP_W), .SUB_W(SUB_W), .PS_W(PS_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .prescale_i (prescale_i),
        .loop_max_i (loop_max_i),
        .hr_cnt_o   (hr_cnt_w),
        .loop_cnt_o (loop_cnt_w),
        .loop_last_o(loop_last_w)
    );

    hrts_edge_detect #(.SYNC_STAGES(SYNC_N)) u_ed (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .loop_last_i(loop_last_w),
        .hr_hit_o   (hr_hit_w),
        .lr_hit_o   (lr_hit_w)
    );

    hrts_capture #(.LOOP_W(LOOP_W), .SUB_W(SUB_W), .PS_W(PS_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .lr_mode_i  (lr_mode_i),
        .prescale_i (prescale_i),
        .hr_hit_i   (hr_hit_w),
        .lr_hit_i   (lr_hit_w),
        .loop_last_i(loop_last_w),
        .hr_cnt_i   (hr_cnt_w),
        .loop_cnt_i (loop_cnt_w),
        .word_o     (cap_word_o),
        .valid_o    (cap_valid_o)
    );

endmodule

// File: rtl/hrts_checker.sv
module hrts_checker
    import hrts_pkg::*;
#(
    parameter int LOOP_W = LOOP_BITS,
    parameter int SUB_W  = SUB_BITS,
    parameter int PS_W   = PS_BITS
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    lr_mode_i,
    input logic [PS_W-1:0]         prescale_i,
    input logic [LOOP_W-1:0]       loop_max_i,
    input logic [LOOP_W+SUB_W-1:0] cap_word_o,
    input logic                    cap_valid_o,
    input logic [SUB_W-1:0]        hr_cnt
);

    localparam logic [SUB_W:0] ONE_EXT = (SUB_W+1)'(1);

    logic [SUB_W-1:0] low_mask;
    always_comb low_mask = SUB_W'((ONE_EXT << (PS_W'(SUB_W) - prescale_i)) - ONE_EXT);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!cap_valid_o && cap_word_o == '0));

    a_r7_word_held: assert property (@(posedge clk) disable iff (rst)
        !cap_valid_o |-> $stable(cap_word_o));

    a_r7_valid_at_loop_start: assert property (@(posedge clk) disable iff (rst)
        cap_valid_o |-> (hr_cnt == '0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (cap_valid_o && prescale_i != '0) |=> !cap_valid_o);

    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        cap_valid_o |-> ((cap_word_o[SUB_W-1:0] & low_mask) == '0));

    a_r9_lr_field_zero: assert property (@(posedge clk) disable iff (rst)
        (cap_valid_o && lr_mode_i) |-> (cap_word_o[SUB_W-1:0] == '0));

    a_r10_loop_in_range: assert property (@(posedge clk) disable iff (rst)
        cap_valid_o |-> (cap_word_o[LOOP_W+SUB_W-1:SUB_W] <= loop_max_i));

endmodule

bind hr_edge_stamp hrts_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .lr_mode_i  (lr_mode_i),
    .prescale_i (prescale_i),
    .loop_max_i (loop_max_i),
    .cap_word_o (cap_word_o),
    .cap_valid_o(cap_valid_o),
    .hr_cnt     (hr_cnt_w)
);

// File: tb/sim_hr_edge_stamp.sv
module sim_hr_edge_stamp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_i = 1'b0;
    logic [1:0]  edge_sel_i = 2'd0;
    logic        lr_mode_i = 1'b0;
    logic [2:0]  prescale_i = 3'd0;
    logic [24:0] loop_max_i = 25'h1FFFFFF;
    logic [31:0] cap_word_o;
    logic        cap_valid_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    hr_edge_stamp u0 (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .lr_mode_i  (lr_mode_i),
        .prescale_i (prescale_i),
        .loop_max_i (loop_max_i),
        .cap_word_o (cap_word_o),
        .cap_valid_o(cap_valid_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic start(input logic [2:0] ps, input logic [24:0] lmax,
                         input logic [1:0] sel, input logic lr);
        rst = 1'b1;
        pin_i = 1'b0;
        prescale_i = ps;
        loop_max_i = lmax;
        edge_sel_i = sel;
        lr_mode_i = lr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Advance to cycle n; any strobe on the way is an unexpected commit.
    task automatic step_to(input int n, input string req);
        int seen_at = -1;
        while (cyc < n) begin
            @(negedge clk);
            if (cyc < n && cap_valid_o && seen_at < 0) seen_at = cyc;
        end
        check(seen_at < 0, req, 32'(seen_at), 32'hFFFFFFFF);
    endtask

    task automatic expect_commit(input int vc, input logic [31:0] w,
                                 input string req, input bit single);
        step_to(vc, "R7 no early strobe");
        check(cap_valid_o == 1'b1, {req, " strobe"}, 32'(cap_valid_o), 32'd1);
        check(cap_word_o == w, {req, " word"}, cap_word_o, w);
        if (single) begin
            @(negedge clk);
            check(cap_valid_o == 1'b0, "R7 one-cycle strobe", 32'(cap_valid_o), 32'd0);
        end
    endtask

    // R1: reset state, and reset after a capture clears the stamp
    task automatic t_reset();
        start(3'd2, 25'h1FFFFFF, 2'd1, 1'b0);
        check(cap_valid_o == 1'b0 && cap_word_o == 32'd0, "R1 after reset",
              cap_word_o, 32'd0);
        step_to(2, "R1");
        pin_i = 1'b1;                       // judged cycle 4: loop 1, sub 0
        expect_commit(8, 32'h0000_0080, "R2", 1'b1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(cap_valid_o == 1'b0 && cap_word_o == 32'd0, "R1 reset clears",
              cap_word_o, 32'd0);
    endtask

    // R6 worked example, R3 rising ignored under falling select
    task automatic t_example();
        start(3'd2, 25'h1FFFFFF, 2'd2, 1'b0);
        step_to(2, "R3 rise ignored");
        pin_i = 1'b1;
        step_to(16, "R3 rise ignored");
        pin_i = 1'b0;                       // judged cycle 18: loop 4, sub 2
        expect_commit(20, 32'h0000_0240, "R6 R4", 1'b1);
    endtask

    task automatic t_rising();
        start(3'd1, 25'h1FFFFFF, 2'd1, 1'b0);
        step_to(4, "R3");
        pin_i = 1'b1;                       // judged 6: loop 3, sub 0
        expect_commit(8, 32'h0000_0180, "R3 rise", 1'b1);
        step_to(10, "R3");
        pin_i = 1'b0;
        step_to(30, "R3 fall ignored");
        check(cap_word_o == 32'h0000_0180, "R7 word held", cap_word_o, 32'h180);
    endtask

    task automatic t_none();
        start(3'd3, 25'h1FFFFFF, 2'd0, 1'b0);
        step_to(3, "R3");
        pin_i = 1'b1;
        step_to(20, "R3 none");
        pin_i = 1'b0;
        step_to(60, "R3 none");
        check(cap_word_o == 32'd0, "R3 none word", cap_word_o, 32'd0);
    endtask

    task automatic t_both();
        start(3'd3, 25'h1FFFFFF, 2'd3, 1'b0);
        step_to(10, "R3");
        pin_i = 1'b1;                       // judged 12: loop 1, sub 4
        expect_commit(16, 32'h0000_00C0, "R3 both rise", 1'b1);
        step_to(20, "R3");
        pin_i = 1'b0;                       // judged 22: loop 2, sub 6
        expect_commit(24, 32'h0000_0160, "R3 both fall", 1'b1);
    endtask

    task automatic t_first_only();
        start(3'd4, 25'h1FFFFFF, 2'd3, 1'b0);
        step_to(3, "R5");
        pin_i = 1'b1;                       // judged 5
        step_to(8, "R5");
        pin_i = 1'b0;                       // judged 10, same loop: ignored
        expect_commit(16, 32'h0000_0028, "R5 first kept", 1'b1);
        step_to(40, "R5 second ignored");
        check(cap_word_o == 32'h0000_0028, "R5 word unchanged", cap_word_o, 32'h28);
    endtask

    task automatic t_last();
        start(3'd3, 25'h1FFFFFF, 2'd1, 1'b0);
        step_to(5, "R8");
        pin_i = 1'b1;                       // judged 7 = last of loop 0
        expect_commit(8, 32'h0000_0070, "R8 last cycle", 1'b1);
    endtask

    task automatic t_lr();
        start(3'd2, 25'h1FFFFFF, 2'd1, 1'b1);
        step_to(4, "R9");
        pin_i = 1'b1;                       // synced at 6, sampled at 7 (loop 1)
        expect_commit(8, 32'h0000_0080, "R9 loop-rate", 1'b1);
    endtask

    task automatic t_wrap();
        start(3'd0, 25'd3, 2'd3, 1'b0);
        step_to(7, "R10");
        pin_i = 1'b1;                       // judged 9 -> coarse 1
        expect_commit(10, 32'h0000_0080, "R10 R2", 1'b0);
        step_to(13, "R10");
        pin_i = 1'b0;                       // judged 15 -> coarse 3
        expect_commit(16, 32'h0000_0180, "R10 ceiling", 1'b0);
        step_to(18, "R10");
        pin_i = 1'b1;                       // judged 20 -> coarse wrapped to 0
        expect_commit(21, 32'h0000_0000, "R10 wrap", 1'b0);
    endtask

    task automatic t_ps7();
        start(3'd7, 25'h1FFFFFF, 2'd1, 1'b0);
        step_to(40, "R6");
        pin_i = 1'b1;                       // judged 42, full 7-bit field
        expect_commit(128, 32'h0000_002A, "R6 full field", 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_example();
        t_rising();
        t_none();
        t_both();
        t_first_only();
        t_last();
        t_lr();
        t_wrap();
        t_ps7();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule